// File: doc/BRIEF.md
# Application Status Flag Register

This block holds the 32-bit status word of a small integer core and works out its condition flags. The execute stage presents the operands, a 3-bit operation code and, for plain logical operations, the result. On the next clock edge the block updates four condition flags: negative (N), zero (Z), carry (C) and overflow (V). A SIMD stage supplies four per-lane greater-or-equal bits. A saturating unit raises `sat_ovf` to set a sticky saturation flag (Q).

Software reaches the register two ways. A move-to-status write (`wr_en`, `wr_data`) replaces every implemented bit. A move-from-status read is the `rd_data` port, which always shows the current register. Bits with no flag behind them always read as zero.

The add and compare-negative codes share one flag rule. The subtract and compare codes share the other. The result itself is discarded outside the block.

Top module: `app_status_reg`

## Requirements
- R1: `rd_data` shows the registered flags in the same cycle. The bit positions are N=31, Z=30, C=29, V=28, Q=27 and greater-or-equal lanes 19:16, with lane 0 at bit 16.
- R2: Every bit outside 31:27 and 19:16 reads as zero. Writing ones to those bits has no effect.
- R3: While `rst_n` is low, the register clears to all zero.
- R4: `sat_ovf` high sets Q on the next edge. Operations never clear Q; only a write can.
- R5: Lane bits load from `simd_ge` only when `op_valid` is high and `op_code`=7. Every other operation leaves them unchanged.
- R6: Codes 1 (add) and 2 (compare-negative) use a+b. N is result bit 31 and Z is set for a zero result. C is the carry out. V is set when the operands share a sign and the result sign differs. Adding zero therefore gives C=0.
- R7: Codes 3 (subtract) and 4 (compare) use a-b. C=1 means no borrow (a>=b unsigned). V is set when the operand signs differ and the result sign differs from a. Comparing a value with itself gives N=0, Z=1, C=1, V=0.
- R8: Code 5 (test-equivalence) sets N and Z from a XOR b and holds C and V.
- R9: Code 6 (logical) sets N and Z from `op_res` and holds C and V.
- R10: A write in the same cycle as any update wins. The register becomes `wr_data` with the R2 bits masked.
- R11: With `op_valid` low, or with code 0, the condition and lane flags hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | 0 none, 1 add, 2 compare-negative, 3 subtract, 4 compare, 5 test-equivalence, 6 logical, 7 SIMD |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_res | input | 32 | Result of a logical operation (code 6) |
| simd_ge | input | 4 | Per-lane greater-or-equal bits (code 7) |
| sat_ovf | input | 1 | Saturating operation overflowed |
| wr_en | input | 1 | Move-to-status write |
| wr_data | input | 32 | Move-to-status data |
| rd_data | output | 32 | Current status word |

## Verification
Every stimulus shows its effect on `rd_data` exactly one clock edge later, because there is one register between the inputs and that port. Reads need no further delay, since `rd_data` is the register itself. The bench drives inputs on the falling edge and advances its reference word at the rising edge. It compares at the next falling edge, so each result is checked in the first cycle it is due and before the next stimulus can change it. The corner cases are self-compare, add of zero, signed overflow and write-versus-update collisions.

// File: rtl/stat_pkg.sv
package stat_pkg;
  localparam int STAT_W   = 32;
  localparam int POS_N    = 31;
  localparam int POS_Z    = 30;
  localparam int POS_C    = 29;
  localparam int POS_V    = 28;
  localparam int POS_Q    = 27;
  localparam int POS_GE   = 16;

  typedef enum logic [2:0] {
    OPC_NOP   = 3'd0,
    OPC_ADDS  = 3'd1,
    OPC_CMN   = 3'd2,
    OPC_SUBS  = 3'd3,
    OPC_CMP   = 3'd4,
    OPC_TEQ   = 3'd5,
    OPC_LOGIC = 3'd6,
    OPC_SIMD  = 3'd7
  } opc_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;
endpackage

// File: rtl/status_flag_gen.sv
module status_flag_gen
  import stat_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              valid,
  input  opc_e              op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [DATA_W-1:0] res,
  input  nzcv_t             cur,
  output nzcv_t             nxt,
  output logic              upd,
  output logic              nz_only
);
  localparam int MSB = DATA_W - 1;

  function automatic nzcv_t add_flags(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    logic [DATA_W:0] s;
    nzcv_t f;
    s   = {1'b0, x} + {1'b0, y};
    f.n = s[MSB];
    f.z = (s[MSB:0] == '0);
    f.c = s[DATA_W];
    f.v = (x[MSB] == y[MSB]) && (s[MSB] != x[MSB]);
    return f;
  endfunction

  function automatic nzcv_t sub_flags(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    logic [DATA_W:0] d;
    nzcv_t f;
    d   = {1'b0, x} + {1'b0, ~y} + {{DATA_W{1'b0}}, 1'b1};
    f.n = d[MSB];
    f.z = (d[MSB:0] == '0);
    f.c = d[DATA_W];
    f.v = (x[MSB] != y[MSB]) && (d[MSB] != x[MSB]);
    return f;
  endfunction

  function automatic nzcv_t nz_flags(input logic [DATA_W-1:0] r, input nzcv_t keep);
    nzcv_t f;
    f   = keep;
    f.n = r[MSB];
    f.z = (r == '0);
    return f;
  endfunction

  always_comb begin
    nxt     = cur;
    upd     = 1'b0;
    nz_only = 1'b0;
    if (valid) begin
      unique case (op)
        OPC_ADDS, OPC_CMN: begin nxt = add_flags(a, b);          upd = 1'b1; end
        OPC_SUBS, OPC_CMP: begin nxt = sub_flags(a, b);          upd = 1'b1; end
        OPC_TEQ:   begin nxt = nz_flags(a ^ b, cur); upd = 1'b1; nz_only = 1'b1; end
        OPC_LOGIC: begin nxt = nz_flags(res, cur);   upd = 1'b1; nz_only = 1'b1; end
        default:   begin nxt = cur; end
      endcase
    end
  end
endmodule

// File: rtl/status_pack.sv
module status_pack
  import stat_pkg::*;
#(
  parameter int GE_LANES = 4
) (
  input  nzcv_t               flags,
  input  logic                q,
  input  logic [GE_LANES-1:0] ge,
  output logic [STAT_W-1:0]   word,
  input  logic [STAT_W-1:0]   wr_word,
  output nzcv_t               wr_flags,
  output logic                wr_q,
  output logic [GE_LANES-1:0] wr_ge
);
  always_comb begin
    word                           = '0;
    word[POS_N]                    = flags.n;
    word[POS_Z]                    = flags.z;
    word[POS_C]                    = flags.c;
    word[POS_V]                    = flags.v;
    word[POS_Q]                    = q;
    word[POS_GE +: GE_LANES]       = ge;
  end

  assign wr_flags = '{n: wr_word[POS_N], z: wr_word[POS_Z], c: wr_word[POS_C], v: wr_word[POS_V]};
  assign wr_q     = wr_word[POS_Q];
  assign wr_ge    = wr_word[POS_GE +: GE_LANES];
endmodule

// File: rtl/app_status_reg.sv
module app_status_reg
  import stat_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int GE_LANES = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                op_valid,
  input  logic [2:0]          op_code,
  input  logic [DATA_W-1:0]   op_a,
  input  logic [DATA_W-1:0]   op_b,
  input  logic [DATA_W-1:0]   op_res,
  input  logic [GE_LANES-1:0] simd_ge,
  input  logic                sat_ovf,
  input  logic                wr_en,
  input  logic [STAT_W-1:0]   wr_data,
  output logic [STAT_W-1:0]   rd_data
);
  localparam logic [STAT_W-1:0] GE_BITS  = STAT_W'(((1 << GE_LANES) - 1) << POS_GE);
  localparam logic [STAT_W-1:0] IMPL_MSK = STAT_W'(32'h1F << POS_Q) | GE_BITS;

  opc_e                op;
  nzcv_t               nzcv_q, nzcv_nx, wr_nzcv;
  logic                q_q, wr_q;
  logic [GE_LANES-1:0] ge_q, wr_ge;

  // Named events for the checks below
  logic nzcv_upd, nz_only, ge_upd, q_set, sw_write;

  assign op       = opc_e'(op_code);
  assign ge_upd   = op_valid && (op == OPC_SIMD);
  assign q_set    = sat_ovf;
  assign sw_write = wr_en;

  status_flag_gen #(.DATA_W(DATA_W)) u_gen (
    .valid   (op_valid),
    .op      (op),
    .a       (op_a),
    .b       (op_b),
    .res     (op_res),
    .cur     (nzcv_q),
    .nxt     (nzcv_nx),
    .upd     (nzcv_upd),
    .nz_only (nz_only)
  );

  status_pack #(.GE_LANES(GE_LANES)) u_pack (
    .flags    (nzcv_q),
    .q        (q_q),
    .ge       (ge_q),
    .word     (rd_data),
    .wr_word  (wr_data),
    .wr_flags (wr_nzcv),
    .wr_q     (wr_q),
    .wr_ge    (wr_ge)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nzcv_q <= '0;
      q_q    <= 1'b0;
      ge_q   <= '0;
    end else if (sw_write) begin
      nzcv_q <= wr_nzcv;
      q_q    <= wr_q;
      ge_q   <= wr_ge;
    end else begin
      if (nzcv_upd) nzcv_q <= nzcv_nx;
      if (q_set)    q_q    <= 1'b1;
      if (ge_upd)   ge_q   <= simd_ge;
    end
  end

  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    sw_write |=> rd_data == ($past(wr_data) & IMPL_MSK)); // R10
  AST_Q_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    q_q && !sw_write |=> q_q); // R4
  AST_Q_SET: assert property (@(posedge clk) disable iff (!rst_n)
    q_set && !sw_write |=> rd_data[POS_Q]); // R4
  AST_GE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ge_upd && !sw_write |=> $stable(rd_data[POS_GE +: GE_LANES])); // R5
  AST_NZ_KEEPS_CV: assert property (@(posedge clk) disable iff (!rst_n)
    nz_only && !sw_write |=> $stable(rd_data[POS_C]) && $stable(rd_data[POS_V])); // R8
  AST_SELF_CMP: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OPC_CMP && op_a == op_b && !sw_write
    |=> rd_data[POS_N:POS_V] == 4'b0110); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid && !sw_write |=> $stable(rd_data[POS_N:POS_V]) && $stable(ge_q)); // R11
endmodule

// File: tb/app_status_reg_tb.sv
`timescale 1ns/1ps
module app_status_reg_tb;
  localparam logic [31:0] MASK = 32'hF80F_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [2:0]  op_code;
  logic [31:0] op_a, op_b, op_res;
  logic [3:0]  simd_ge;
  logic        sat_ovf;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;

  int errs   = 0;
  int checks = 0;
  logic [31:0] model;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  app_status_reg u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_a(op_a), .op_b(op_b), .op_res(op_res), .simd_ge(simd_ge),
    .sat_ovf(sat_ovf), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  function automatic logic [31:0] ref_next(logic [31:0] cur, logic v, logic [2:0] op,
      logic [31:0] a, logic [31:0] b, logic [31:0] r, logic [3:0] ge, logic sat,
      logic we, logic [31:0] wd);
    logic [31:0] nx, rr;
    longint sl;
    logic [32:0] s;
    if (we) return wd & MASK;
    nx = cur;
    if (v) begin
      case (op)
        3'd1, 3'd2: begin
          s = {1'b0, a} + {1'b0, b};
          rr = s[31:0];
          sl = longint'($signed(a)) + longint'($signed(b));
          nx[31] = rr[31]; nx[30] = (rr == 0); nx[29] = s[32];
          nx[28] = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
        end
        3'd3, 3'd4: begin
          rr = a - b;
          sl = longint'($signed(a)) - longint'($signed(b));
          nx[31] = rr[31]; nx[30] = (rr == 0); nx[29] = (a >= b);
          nx[28] = (sl > 64'sd2147483647) || (sl < -64'sd2147483648);
        end
        3'd5: begin rr = a ^ b; nx[31] = rr[31]; nx[30] = (rr == 0); end
        3'd6: begin nx[31] = r[31]; nx[30] = (r == 0); end
        3'd7: nx[19:16] = ge;
        default: ;
      endcase
    end
    if (sat) nx[27] = 1'b1;
    return nx;
  endfunction

  function automatic string req_for(logic v, logic [2:0] op, logic sat, logic we);
    if (we) return "R10";
    if (sat) return "R4";
    if (!v || op == 3'd0) return "R11";
    case (op)
      3'd1, 3'd2: return "R6";
      3'd3, 3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] exp);
    checks++;
    if (rd_data !== exp) begin
      errs++;
      $display("FAIL %s: rd_data=%h expected=%h", tag, rd_data, exp);
    end
  endtask

  task automatic step(string tag, logic v, logic [2:0] op, logic [31:0] a, logic [31:0] b,
      logic [31:0] r, logic [3:0] ge, logic sat, logic we, logic [31:0] wd);
    op_valid = v; op_code = op; op_a = a; op_b = b; op_res = r;
    simd_ge = ge; sat_ovf = sat; wr_en = we; wr_data = wd;
    model = ref_next(model, v, op, a, b, r, ge, sat, we, wd);
    @(posedge clk);
    @(negedge clk);
    check(tag, model);
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 5))
      0: return 32'h0;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8000_0000;
      3: return 32'h7FFF_FFFF;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0; op_valid = 0; op_code = 0; op_a = 0; op_b = 0; op_res = 0;
    simd_ge = 0; sat_ovf = 0; wr_en = 1'b1; wr_data = 32'hFFFF_FFFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    model = 32'h0;
    check("R3", model);
    rst_n = 1'b1;

    step("R2", 0, 0, 0, 0, 0, 0, 0, 1, 32'hFFFF_FFFF);
    step("R1", 0, 0, 0, 0, 0, 0, 0, 1, 32'hA005_0000);
    step("R7", 1, 3'd4, 32'h1234, 32'h1234, 0, 0, 0, 0, 0);
    step("R6", 1, 3'd1, 32'h1234, 32'h0, 0, 0, 0, 0, 0);
    step("R7", 1, 3'd4, 32'h5, 32'h5, 0, 0, 0, 0, 0);
    step("R6", 1, 3'd2, 32'h5, 32'h0, 0, 0, 0, 0, 0);
    step("R6", 1, 3'd1, 32'h7FFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    step("R6", 1, 3'd1, 32'hFFFF_FFFF, 32'h1, 0, 0, 0, 0, 0);
    step("R7", 1, 3'd3, 32'h8000_0000, 32'h1, 0, 0, 0, 0, 0);
    step("R7", 1, 3'd3, 32'h0, 32'h1, 0, 0, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1, 32'h3000_0000);
    step("R8", 1, 3'd5, 32'h9ABC, 32'h9ABC, 0, 0, 0, 0, 0);
    step("R9", 1, 3'd6, 0, 0, 32'h8000_0000, 0, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R4", 1, 3'd3, 32'h2, 32'h2, 0, 0, 0, 0, 0);
    step("R4", 1, 3'd7, 0, 0, 0, 4'hF, 0, 0, 0);
    step("R4", 0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    step("R5", 1, 3'd7, 0, 0, 0, 4'hA, 0, 0, 0);
    step("R5", 1, 3'd1, 32'h3, 32'h4, 0, 4'h5, 0, 0, 0);
    step("R10", 1, 3'd1, 32'h7FFF_FFFF, 32'h1, 0, 4'h3, 1, 1, 32'h4000_0000);
    step("R10", 1, 3'd7, 0, 0, 0, 4'hF, 1, 1, 32'h0008_0001);
    step("R11", 0, 3'd1, 32'h0, 32'h0, 0, 4'hF, 0, 0, 0);
    step("R11", 1, 3'd0, 32'h0, 32'h0, 0, 4'hF, 0, 0, 0);

    for (int i = 0; i < 600; i++) begin
      logic v, sat, we;
      logic [2:0] op;
      logic [31:0] a, b;
      v   = ($urandom_range(0, 9) != 0);
      op  = 3'($urandom);
      sat = ($urandom_range(0, 11) == 0);
      we  = ($urandom_range(0, 9) == 0);
      a   = pick();
      b   = ($urandom_range(0, 5) == 0) ? a : pick();
      step(req_for(v, op, sat, we), v, op, a, b, pick(), 4'($urandom), sat, we, $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule